// File: doc/BRIEF.md
# Analog Monitor Hotplug Detect Sequencer

This block runs a forced presence-detect cycle on an analog video output. A host write sets a go bit, which reads back high for as long as the cycle runs and drops by itself when the cycle ends. During the cycle the block can hold the DAC off. It waits through a programmable warmup, latches the per-channel monitor-sense bits coming from a comparator front end, and then polls a sense-done indication on a programmable sample period. When the cycle finishes it reports whether a monitor is attached and raises an interrupt status bit. The host clears that bit by writing one to it.

The comparator front end is abstract: its sense bits and its done flag arrive as asynchronous digital inputs. If done is never seen within a programmable number of sample ticks, the cycle is aborted and a timeout flag is raised. A configuration bit runs the whole sequence twice back to back, and the result comes from the second pass. After each reset a flag marks that one explicit cycle is still owed. A probe request runs that cycle only while the flag is set; otherwise the probe only reads the latched status.

Top module: `hpd_detect_seq`

## Requirements
- R1: After reset the go bit, interrupt status, timeout flag, presence result and DAC output are all low, and the cycle-owed flag is high.
- R2: A control write with the go field (bit 0) set while idle starts a cycle. The go bit then reads high for exactly W+S+2 clocks and clears itself, where W is the warmup count and S the sample period, provided done is already asserted at the first sample tick.
- R3: The presence result is the OR of the channel sense bits latched at the end of the warmup, after a two-flop synchronizer. Sense changes after that point have no effect on the result, and the result is held while a cycle runs.
- R4: While a cycle runs with the blank field (bit 2) set, the DAC output is low. With blank clear, or once the cycle ends, the DAC output follows the host DAC-enable field (bit 1).
- R5: Completion or timeout sets the interrupt status. A control write with the clear field (bit 4) set clears it, and a set in the same cycle wins.
- R6: If done is not seen at any of P sample ticks, the cycle aborts after W+1+P*(S+1) clocks. The timeout flag is set, while the presence result and the cycle-owed flag are unchanged. The next cycle start clears the timeout flag.
- R7: With the twice field (bit 3) set, two complete passes run back to back, so the go bit is high for 2*(W+S+2) clocks.
- R8: A probe request starts a cycle only while the cycle-owed flag is set. Successful completion clears the flag; a timeout leaves it set.
- R9: While a cycle runs, the go, DAC-enable, blank and twice fields of a control write are ignored, but the clear field still acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control fields: go, DAC enable, blank, twice, interrupt clear |
| probe | input | 1 | Presence query; starts a cycle if one is still owed |
| cfg_warm | input | WARM_W | Warmup length in clocks |
| cfg_smp | input | SMP_W | Sample period: clocks between sample ticks minus one |
| cfg_per | input | PER_W | Sample ticks allowed before timeout |
| sense_in | input | NCH | Asynchronous per-channel monitor-sense bits |
| sense_done | input | 1 | Asynchronous comparator done flag |
| trig_o | output | 1 | Go bit readback; high while a cycle runs |
| present_o | output | 1 | Monitor attached result |
| irq_o | output | 1 | Interrupt status |
| tmo_o | output | 1 | Last cycle timed out |
| need_o | output | 1 | An explicit cycle is still owed since reset |
| dac_o | output | 1 | DAC enable after blanking |
| sense_o | output | NCH | Sense bits latched in the last pass |

## Verification
The assertions assume that the timing inputs stay unchanged while a cycle runs. They also assume that the sense inputs are steady for at least two clocks before the warmup ends. The stimulus only reprograms the timing inputs while the go bit reads low. It sets the sense and done inputs before starting a cycle, or changes them well after the warmup has finished. The checks are then built around four points: the exact busy length, the point where the sense bits are latched, the DAC blanking window and the handling of writes during a cycle.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WARM = 2'd1,
      ST_SAMP = 2'd2
   } seq_st_t;

   localparam int CTL_W   = 5;
   localparam int F_GO    = 0;
   localparam int F_DAC   = 1;
   localparam int F_BLANK = 2;
   localparam int F_TWICE = 3;
   localparam int F_ICLR  = 4;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int SR_W = W * STAGES;

   logic [SR_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[SR_W-W-1:0], d};
   end

   assign q = sr[SR_W-1 -: W];
endmodule

// File: rtl/hpd_cfg_reg.sv
module hpd_cfg_reg
   import hpd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             busy,
   input  logic             fin_evt,
   output logic             dac_en_q,
   output logic             blank_q,
   output logic             twice_q,
   output logic             irq_q,
   output logic             go_req
);
   logic idle_wr;

   assign idle_wr = wr && !busy;
   assign go_req  = idle_wr && wdata[F_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_en_q <= 1'b0;
         blank_q  <= 1'b0;
         twice_q  <= 1'b0;
      end else if (idle_wr) begin
         dac_en_q <= wdata[F_DAC];
         blank_q  <= wdata[F_BLANK];
         twice_q  <= wdata[F_TWICE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     irq_q <= 1'b0;
      else if (fin_evt)               irq_q <= 1'b1;
      else if (wr && wdata[F_ICLR])   irq_q <= 1'b0;
   end
endmodule

// File: rtl/hpd_seq_fsm.sv
module hpd_seq_fsm
   import hpd_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int WARM_W = 8,
   parameter int SMP_W  = 8,
   parameter int PER_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              twice,
   input  logic [WARM_W-1:0] cfg_warm,
   input  logic [SMP_W-1:0]  cfg_smp,
   input  logic [PER_W-1:0]  cfg_per,
   input  logic [NCH-1:0]    sense_s,
   input  logic              done_s,
   output logic              busy,
   output logic              fin_evt,
   output logic [NCH-1:0]    sense_lat,
   output logic              present_q,
   output logic              tmo_q,
   output logic              need_q
);
   seq_st_t           st;
   logic [WARM_W-1:0] wcnt;
   logic [SMP_W-1:0]  scnt;
   logic [PER_W-1:0]  pcnt;
   logic              second;

   logic tick, pass_end, again, fin_ok, fin_tmo;

   assign busy     = (st != ST_IDLE);
   assign tick     = (st == ST_SAMP) && (scnt == '0);
   assign pass_end = tick && done_s;
   assign again    = pass_end && twice && !second;
   assign fin_ok   = pass_end && !again;
   assign fin_tmo  = tick && !done_s && (pcnt <= PER_W'(1));
   assign fin_evt  = fin_ok || fin_tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         wcnt      <= '0;
         scnt      <= '0;
         pcnt      <= '0;
         second    <= 1'b0;
         sense_lat <= '0;
         present_q <= 1'b0;
         tmo_q     <= 1'b0;
         need_q    <= 1'b1;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_WARM;
                  wcnt   <= cfg_warm;
                  second <= 1'b0;
                  tmo_q  <= 1'b0;
               end
            end
            ST_WARM: begin
               if (wcnt == '0) begin
                  sense_lat <= sense_s;
                  st        <= ST_SAMP;
                  scnt      <= cfg_smp;
                  pcnt      <= cfg_per;
               end else begin
                  wcnt <= wcnt - WARM_W'(1);
               end
            end
            ST_SAMP: begin
               if (!tick) begin
                  scnt <= scnt - SMP_W'(1);
               end else if (again) begin
                  second <= 1'b1;
                  st     <= ST_WARM;
                  wcnt   <= cfg_warm;
               end else if (fin_ok) begin
                  st        <= ST_IDLE;
                  present_q <= |sense_lat;
                  need_q    <= 1'b0;
               end else if (fin_tmo) begin
                  st    <= ST_IDLE;
                  tmo_q <= 1'b1;
               end else begin
                  pcnt <= pcnt - PER_W'(1);
                  scnt <= cfg_smp;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hpd_detect_seq.sv
module hpd_detect_seq
   import hpd_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int WARM_W      = 8,
   parameter int SMP_W       = 8,
   parameter int PER_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              probe,
   input  logic [WARM_W-1:0] cfg_warm,
   input  logic [SMP_W-1:0]  cfg_smp,
   input  logic [PER_W-1:0]  cfg_per,
   input  logic [NCH-1:0]    sense_in,
   input  logic              sense_done,
   output logic              trig_o,
   output logic              present_o,
   output logic              irq_o,
   output logic              tmo_o,
   output logic              need_o,
   output logic              dac_o,
   output logic [NCH-1:0]    sense_o
);
   localparam int SYNC_W = NCH + 1;

   if (NCH < 1) begin : g_bad_nch
      $error("hpd_detect_seq: NCH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hpd_detect_seq: SYNC_STAGES must be at least 2");
   end
   if (PER_W < 1 || SMP_W < 1 || WARM_W < 1) begin : g_bad_w
      $error("hpd_detect_seq: counter widths must be positive");
   end

   logic [SYNC_W-1:0] sync_q;
   logic [NCH-1:0]    sense_s;
   logic              done_s;
   logic              busy, fin_evt, go_req, start;
   logic              dac_en_q, blank_q, twice_q, irq_q;
   logic              present_q, tmo_q, need_q;
   logic [NCH-1:0]    sense_lat;

   hpd_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sense_done, sense_in}),
      .q     (sync_q)
   );

   assign sense_s = sync_q[NCH-1:0];
   assign done_s  = sync_q[NCH];

   hpd_cfg_reg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctl_wr),
      .wdata    (ctl_wdata),
      .busy     (busy),
      .fin_evt  (fin_evt),
      .dac_en_q (dac_en_q),
      .blank_q  (blank_q),
      .twice_q  (twice_q),
      .irq_q    (irq_q),
      .go_req   (go_req)
   );

   assign start = !busy && (go_req || (probe && need_q));

   hpd_seq_fsm #(
      .NCH(NCH), .WARM_W(WARM_W), .SMP_W(SMP_W), .PER_W(PER_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .twice     (twice_q),
      .cfg_warm  (cfg_warm),
      .cfg_smp   (cfg_smp),
      .cfg_per   (cfg_per),
      .sense_s   (sense_s),
      .done_s    (done_s),
      .busy      (busy),
      .fin_evt   (fin_evt),
      .sense_lat (sense_lat),
      .present_q (present_q),
      .tmo_q     (tmo_q),
      .need_q    (need_q)
   );

   assign trig_o    = busy;
   assign present_o = present_q;
   assign irq_o     = irq_q;
   assign tmo_o     = tmo_q;
   assign need_o    = need_q;
   assign dac_o     = dac_en_q && !(busy && blank_q);
   assign sense_o   = sense_lat;
endmodule

// File: rtl/hpd_detect_seq_chk.sv
module hpd_detect_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic trig_o,
   input logic irq_o,
   input logic tmo_o,
   input logic need_o,
   input logic present_o,
   input logic dac_o,
   input logic blank_q,
   input logic dac_en_q
);
   AST_TRIG_DROP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trig_o) |-> irq_o); // R5

   AST_BLANK_DAC: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && blank_q) |-> !dac_o); // R4

   AST_TMO_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_o) |-> $fell(trig_o)); // R6

   AST_NEED_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(need_o) |-> ($fell(trig_o) && !tmo_o)); // R8

   AST_PRESENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && $past(trig_o)) |-> $stable(present_o)); // R3

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && $past(trig_o)) |-> $stable(dac_en_q)); // R9
endmodule

bind hpd_detect_seq hpd_detect_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig_o    (trig_o),
   .irq_o     (irq_o),
   .tmo_o     (tmo_o),
   .need_o    (need_o),
   .present_o (present_o),
   .dac_o     (dac_o),
   .blank_q   (blank_q),
   .dac_en_q  (dac_en_q)
);

// File: tb/hpd_detect_seq_tb_top.sv
`timescale 1ns/1ps
module hpd_detect_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic       probe = 1'b0;
   logic [7:0] cfg_warm = 8'd4;
   logic [7:0] cfg_smp = 8'd3;
   logic [3:0] cfg_per = 4'd15;
   logic [1:0] sense_in = '0;
   logic       sense_done = 1'b0;
   logic       trig_o, present_o, irq_o, tmo_o, need_o, dac_o;
   logic [1:0] sense_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   hpd_detect_seq dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .probe(probe), .cfg_warm(cfg_warm), .cfg_smp(cfg_smp), .cfg_per(cfg_per),
      .sense_in(sense_in), .sense_done(sense_done), .trig_o(trig_o),
      .present_o(present_o), .irq_o(irq_o), .tmo_o(tmo_o), .need_o(need_o),
      .dac_o(dac_o), .sense_o(sense_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // fields: bit0 go, bit1 dac, bit2 blank, bit3 twice, bit4 irq clear
   task automatic wr(input logic go, input logic dac, input logic blk,
                     input logic tw, input logic clr);
      ctl_wr    = 1'b1;
      ctl_wdata = {clr, tw, blk, dac, go};
      @(negedge clk);
      ctl_wr    = 1'b0;
      ctl_wdata = '0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (trig_o && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 trig", trig_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 tmo", tmo_o, 0);
      chk("R1 need", need_o, 1);
      chk("R1 present", present_o, 0);
      chk("R1 dac", dac_o, 0);
   endtask

   task automatic t_probe_first();
      int n;
      cfg_warm = 8'd4; cfg_smp = 8'd3; cfg_per = 4'd15;
      sense_in = 2'b10; sense_done = 1'b1;
      wr(0, 1, 1, 0, 0);
      chk("R4 dac idle", dac_o, 1);
      probe = 1'b1;
      @(negedge clk);
      probe = 1'b0;
      chk("R8 probe starts", trig_o, 1);
      chk("R4 blanked", dac_o, 0);
      busy_len(n);
      chk("R2 busy length", n, 9);
      chk("R3 present", present_o, 1);
      chk("R3 sense latched", sense_o, 2);
      chk("R8 need cleared", need_o, 0);
      chk("R5 irq set", irq_o, 1);
      chk("R4 dac restored", dac_o, 1);
   endtask

   task automatic t_probe_again();
      probe = 1'b1;
      @(negedge clk);
      probe = 1'b0;
      chk("R8 probe no start", trig_o, 0);
      repeat (3) @(negedge clk);
      chk("R8 still idle", trig_o, 0);
   endtask

   task automatic t_irq_clear();
      wr(0, 1, 1, 0, 1);
      chk("R5 irq cleared", irq_o, 0);
   endtask

   task automatic t_sense_window();
      int n;
      sense_in = 2'b00; sense_done = 1'b0;
      repeat (3) @(negedge clk);
      wr(1, 1, 0, 0, 0);
      chk("R2 go starts", trig_o, 1);
      chk("R4 unblanked", dac_o, 1);
      repeat (12) @(negedge clk);
      sense_in = 2'b11; sense_done = 1'b1;
      busy_len(n);
      chk("R3 late sense ignored", present_o, 0);
      chk("R3 late sense not latched", sense_o, 0);
   endtask

   task automatic t_busy_writes();
      int n;
      sense_in = 2'b01; sense_done = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 irq before", irq_o, 1);
      wr(1, 1, 0, 0, 0);
      n = 1;
      @(negedge clk); n++;
      wr(1, 0, 1, 1, 1);
      n++;
      chk("R9 clear acts while busy", irq_o, 0);
      chk("R9 blank ignored", dac_o, 1);
      while (trig_o && n < 2000) begin
         @(negedge clk);
         if (trig_o) n++;
      end
      chk("R9 go ignored length", n, 9);
      chk("R9 dac field ignored", dac_o, 1);
      chk("R3 present one channel", present_o, 1);
      chk("R5 irq set at end", irq_o, 1);
   endtask

   task automatic t_twice();
      int n;
      wr(1, 1, 0, 1, 0);
      busy_len(n);
      chk("R7 twice length", n, 18);
      chk("R7 present", present_o, 1);
   endtask

   task automatic t_timeout();
      int n;
      cfg_smp = 8'd2; cfg_per = 4'd3;
      sense_in = 2'b00; sense_done = 1'b0;
      repeat (3) @(negedge clk);
      wr(0, 1, 0, 0, 1);
      chk("R5 irq cleared", irq_o, 0);
      wr(1, 1, 0, 0, 0);
      busy_len(n);
      chk("R6 timeout length", n, 14);
      chk("R6 tmo flag", tmo_o, 1);
      chk("R6 irq on timeout", irq_o, 1);
      chk("R6 present kept", present_o, 1);
      chk("R6 need kept", need_o, 0);
      sense_done = 1'b1;
      repeat (3) @(negedge clk);
      wr(1, 1, 0, 0, 0);
      chk("R6 tmo cleared on start", tmo_o, 0);
      busy_len(n);
      chk("R2 length short period", n, 8);
   endtask

   task automatic t_need_after_tmo();
      int n;
      sense_done = 1'b0;
      do_reset();
      chk("R1 need after reset", need_o, 1);
      probe = 1'b1;
      @(negedge clk);
      probe = 1'b0;
      busy_len(n);
      chk("R6 timeout via probe", tmo_o, 1);
      chk("R8 need kept on timeout", need_o, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_probe_first();
      t_probe_again();
      t_irq_clear();
      t_sense_window();
      t_busy_writes();
      t_twice();
      t_timeout();
      t_need_after_tmo();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule